// File: doc/BRIEF.md
# Burst-Aware AHB Bridge with Error Recovery

This block joins an upstream AHB master to a downstream AHB slave when both sides run on the same clock. Each address phase accepted from the master is registered and presented downstream one cycle later. Write data and read data pass straight through, and the downstream data phase completion is mirrored back to the master. Between beats of an open burst the bridge keeps the downstream burst legal by driving BUSY in the gap cycles. It tracks the beat count of fixed-length bursts so that it knows when a burst has ended.

The main job of the bridge is deciding what to drive downstream after the slave answers a burst beat with ERROR. A master may go on with the rest of the burst or abandon it. The bridge does not guess. It relays the two-cycle error upstream and forces downstream HTRANS to IDLE from the first error cycle. It then watches the master's next transfer type. NONSEQ or SEQ means the burst goes on, IDLE means it was dropped, and BUSY means keep waiting. A run of BUSY cycles of programmable length ends the wait and is taken as a cancellation. A continued remainder cannot carry on the broken downstream burst, so it is reissued as a fresh undefined-length burst.

The bridge assumes it is the only slave on its upstream segment, so its own ready output qualifies the master's address phase. Split, retry, locking, protection signals and clock crossing are not handled.

Top module: `ahb_burst_bridge`

## Requirements
- R1: After reset (active-low `hresetn`), `m_htrans` is IDLE (2'b00), `s_hreadyout` is 1 and `s_hresp` is OKAY (0).
- R2: A NONSEQ (2'b10) or SEQ (2'b11) address phase accepted while `s_hreadyout` is 1 appears on the downstream address, control and `m_htrans` in the next cycle, with `s_hreadyout` low in that cycle. In the cycle after that, `s_hreadyout` follows `m_hready`. `m_hwdata` always equals `s_hwdata` and `s_hrdata` always equals `m_hrdata`.
- R3: HBURST codes are SINGLE=0, INCR=1, WRAP4=2, INCR4=3, WRAP8=4, INCR8=5, WRAP16=6 and INCR16=7, giving 1, undefined, 4, 4, 8, 8, 16 and 16 beats. In each gap cycle between forwarded beats, `m_htrans` is BUSY (2'b01) while beats remain. After the last beat of a SINGLE or fixed-length burst it is IDLE. After an INCR beat it stays BUSY until the master's IDLE or NONSEQ has been accepted.
- R4: An upstream BUSY is accepted with zero wait states and an OKAY response. While the burst is still open, downstream shows BUSY.
- R5: When the downstream slave gives its first error cycle (`m_hready`=0, `m_hresp`=1), upstream gets `s_hreadyout`=0 with `s_hresp`=1 in the next cycle. In the cycle after that, upstream gets `s_hreadyout`=1 with `s_hresp`=1.
- R6: `m_htrans` is IDLE from the first downstream error cycle until the master's continuation is forwarded.
- R7: If the master presents SEQ after an error, whether in the second upstream error cycle or while waiting, it is forwarded as NONSEQ with `m_hburst`=INCR. Following beats are forwarded as SEQ with BUSY gaps.
- R8: If the master presents IDLE after an error, the burst is closed and downstream stays IDLE.
- R9: If the master presents BUSY after an error, it gets zero-wait OKAY responses and `m_htrans` stays IDLE.
- R10: After the second upstream error cycle, if `TMO` (default 16) further consecutive BUSY cycles pass, the burst is treated as cancelled. A SEQ accepted later is forwarded as a stand-alone NONSEQ with `m_hburst`=SINGLE and an IDLE gap after it. A SEQ presented in the last waiting cycle still counts as a continuation.
- R11: A NONSEQ presented after an error is forwarded unchanged, with its own HBURST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Shared clock |
| hresetn | input | 1 | Synchronous active-low reset |
| s_haddr | input | AW | Upstream address |
| s_htrans | input | 2 | Upstream transfer type |
| s_hwrite | input | 1 | Upstream write flag |
| s_hsize | input | 3 | Upstream transfer size |
| s_hburst | input | 3 | Upstream burst type |
| s_hwdata | input | DW | Upstream write data |
| s_hrdata | output | DW | Read data returned upstream |
| s_hreadyout | output | 1 | Upstream transfer-done indication |
| s_hresp | output | 1 | Upstream response, 1 = ERROR |
| m_haddr | output | AW | Downstream address |
| m_htrans | output | 2 | Downstream transfer type chosen by the bridge |
| m_hwrite | output | 1 | Downstream write flag |
| m_hsize | output | 3 | Downstream transfer size |
| m_hburst | output | 3 | Downstream burst type |
| m_hwdata | output | DW | Downstream write data |
| m_hrdata | input | DW | Downstream read data |
| m_hready | input | 1 | Downstream transfer-done indication |
| m_hresp | input | 1 | Downstream response, 1 = ERROR |

## Verification
Error-free bursts are run through all eight HBURST codes. These runs separate the BUSY gap inside a burst from the IDLE or BUSY gap after it, and they show whether the beat counter ends a fixed burst at the right beat. An INCR4 burst is then failed on its second beat, and the master answers in five ways: SEQ at once, BUSY then SEQ, IDLE, NONSEQ, and BUSY for the full timeout. These separate continuation (NONSEQ with INCR and BUSY gaps) from cancellation (IDLE, or SINGLE with an IDLE gap). A SEQ in the final waiting cycle checks the exact timeout boundary. An upstream BUSY inserted mid-burst checks zero-wait BUSY forwarding.

// File: rtl/ahb_bridge_pkg.sv
// Package: shared transfer codes, bridge states and burst-length decode.
// Assumes AHB encodings for HTRANS and HBURST.
package ahb_bridge_pkg;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [2:0] BR_SINGLE = 3'd0;
    localparam logic [2:0] BR_INCR   = 3'd1;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // no downstream data phase pending
        ST_ADDR = 3'd1,   // downstream address phase driven
        ST_DATA = 3'd2,   // downstream data phase in progress
        ST_ERR1 = 3'd3,   // first upstream error cycle
        ST_ERR2 = 3'd4,   // second upstream error cycle, master decides
        ST_WAIT = 3'd5    // post-error wait on master intent
    } br_state_e;

    // Number of beats a burst code implies (INCR reports 1, treated as open-ended)
    function automatic logic [4:0] burst_beats(input logic [2:0] code);
        logic [4:0] n;
        if (code < 3'd2) n = 5'd1;
        else             n = 5'(1 << ((code >> 1) + 3'd1));
        return n;
    endfunction

endpackage

// File: rtl/ahb_err_timer.sv
// Module: counts consecutive BUSY cycles in the post-error wait state and
// flags the last one. Assumes TMO >= 2. Cleared whenever the wait is left.
module ahb_err_timer #(
    parameter int TMO = 16
) (
    input  logic hclk,
    input  logic hresetn,
    input  logic in_wait,
    input  logic run,
    output logic hit
);
    localparam int CW = (TMO < 2) ? 1 : $clog2(TMO);
    localparam logic [CW-1:0] LAST = CW'(TMO - 1);

    logic [CW-1:0] cnt;

    // Count BUSY cycles spent waiting; restart from zero outside the wait
    always_ff @(posedge hclk) begin
        if (!hresetn)       cnt <= '0;
        else if (!in_wait)  cnt <= '0;
        else if (run)       cnt <= cnt + 1'b1;
    end

    // Expiry is the last BUSY cycle of the allowed window
    always_comb hit = run && (cnt == LAST);

endmodule

// File: rtl/ahb_burst_track.sv
// Module: keeps whether a downstream burst is open, the beats left in a
// fixed-length burst, and picks the transfer type and burst code to forward.
// Assumes the FSM raises take only for accepted NONSEQ/SEQ, close otherwise.
module ahb_burst_track
    import ahb_bridge_pkg::*;
(
    input  logic       hclk,
    input  logic       hresetn,
    input  logic       take,
    input  logic       close,
    input  logic       post_err,
    input  logic [1:0] up_trans,
    input  logic [2:0] up_burst,
    output logic       open,
    output logic [1:0] fwd_trans,
    output logic [2:0] fwd_burst
);
    logic       open_q;
    logic [4:0] left_q;
    logic [2:0] burst_q;
    logic [4:0] new_beats;

    // Choose how the accepted transfer is presented downstream
    always_comb begin
        new_beats = burst_beats(up_burst);
        if (up_trans == TR_NONSEQ) begin
            fwd_trans = TR_NONSEQ;
            fwd_burst = up_burst;
        end else if (open_q) begin
            fwd_trans = TR_SEQ;
            fwd_burst = burst_q;
        end else if (post_err) begin
            fwd_trans = TR_NONSEQ;
            fwd_burst = BR_INCR;
        end else begin
            fwd_trans = TR_NONSEQ;
            fwd_burst = BR_SINGLE;
        end
    end

    // Update burst-open state and beat budget on each accepted beat
    always_ff @(posedge hclk) begin
        if (!hresetn) begin
            open_q  <= 1'b0;
            left_q  <= '0;
            burst_q <= BR_SINGLE;
        end else if (take) begin
            burst_q <= fwd_burst;
            if (up_trans == TR_NONSEQ) begin
                left_q <= new_beats - 5'd1;
                open_q <= (up_burst == BR_INCR) || (new_beats != 5'd1);
            end else if (open_q) begin
                left_q <= left_q - 5'd1;
                open_q <= (burst_q == BR_INCR) || (left_q != 5'd1);
            end else begin
                left_q <= '0;
                open_q <= post_err;
            end
        end else if (close) begin
            open_q <= 1'b0;
        end
    end

    always_comb open = open_q;

endmodule

// File: rtl/ahb_err_fsm.sv
// Module: bridge sequencing. Tracks the downstream phase, relays the
// two-cycle error upstream and resolves the master's intent afterwards.
// Assumes the bridge is the only upstream slave (its ready qualifies HTRANS).
module ahb_err_fsm
    import ahb_bridge_pkg::*;
(
    input  logic       hclk,
    input  logic       hresetn,
    input  logic [1:0] up_trans,
    input  logic       m_hready,
    input  logic       m_hresp,
    input  logic       tmo_hit,
    output br_state_e  state,
    output logic       s_hreadyout,
    output logic       s_hresp,
    output logic       take,
    output logic       close,
    output logic       post_err,
    output logic       in_wait,
    output logic       tmo_run
);
    br_state_e nxt;
    logic      err_hit;

    // Upstream handshake and decision strobes from the current state
    always_comb begin
        case (state)
            ST_ADDR, ST_ERR1: s_hreadyout = 1'b0;
            ST_DATA:          s_hreadyout = m_hready && !m_hresp;
            default:          s_hreadyout = 1'b1;
        endcase
        s_hresp  = (state == ST_ERR1) || (state == ST_ERR2);
        err_hit  = (state == ST_DATA) && m_hresp && !m_hready;
        post_err = (state == ST_ERR2) || (state == ST_WAIT);
        in_wait  = (state == ST_WAIT);
        tmo_run  = in_wait && (up_trans == TR_BUSY);
        take     = s_hreadyout && up_trans[1];
        close    = err_hit || tmo_hit || (s_hreadyout && (up_trans == TR_IDLE));
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (take) nxt = ST_ADDR;
            ST_ADDR: if (m_hready) nxt = ST_DATA;
            ST_DATA: begin
                if (err_hit)       nxt = ST_ERR1;
                else if (m_hready) nxt = take ? ST_ADDR : ST_IDLE;
            end
            ST_ERR1: nxt = ST_ERR2;
            ST_ERR2: begin
                if (take)                       nxt = ST_ADDR;
                else if (up_trans == TR_IDLE)   nxt = ST_IDLE;
                else                            nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (take)                                nxt = ST_ADDR;
                else if ((up_trans == TR_IDLE) || tmo_hit) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge hclk) begin
        if (!hresetn) state <= ST_IDLE;
        else          state <= nxt;
    end

endmodule

// File: rtl/ahb_burst_bridge.sv
// Module: top of the same-clock AHB bridge. Registers accepted address
// phases, passes data through, and chooses downstream HTRANS, including
// the safe IDLE after a downstream error. Assumes sole upstream slave.
module ahb_burst_bridge
    import ahb_bridge_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int TMO = 16
) (
    input  logic          hclk,
    input  logic          hresetn,
    input  logic [AW-1:0] s_haddr,
    input  logic [1:0]    s_htrans,
    input  logic          s_hwrite,
    input  logic [2:0]    s_hsize,
    input  logic [2:0]    s_hburst,
    input  logic [DW-1:0] s_hwdata,
    output logic [DW-1:0] s_hrdata,
    output logic          s_hreadyout,
    output logic          s_hresp,
    output logic [AW-1:0] m_haddr,
    output logic [1:0]    m_htrans,
    output logic          m_hwrite,
    output logic [2:0]    m_hsize,
    output logic [2:0]    m_hburst,
    output logic [DW-1:0] m_hwdata,
    input  logic [DW-1:0] m_hrdata,
    input  logic          m_hready,
    input  logic          m_hresp
);
    br_state_e     state;
    logic          take, close, post_err, in_wait, tmo_run, tmo_hit, open;
    logic [1:0]    fwd_trans;
    logic [2:0]    fwd_burst;
    logic [AW-1:0] addr_q;
    logic [1:0]    trans_q;
    logic          write_q;
    logic [2:0]    size_q, burst_q;

    ahb_err_fsm u_fsm (
        .hclk(hclk), .hresetn(hresetn), .up_trans(s_htrans),
        .m_hready(m_hready), .m_hresp(m_hresp), .tmo_hit(tmo_hit),
        .state(state), .s_hreadyout(s_hreadyout), .s_hresp(s_hresp),
        .take(take), .close(close), .post_err(post_err),
        .in_wait(in_wait), .tmo_run(tmo_run)
    );

    ahb_err_timer #(.TMO(TMO)) u_tmo (
        .hclk(hclk), .hresetn(hresetn), .in_wait(in_wait),
        .run(tmo_run), .hit(tmo_hit)
    );

    ahb_burst_track u_trk (
        .hclk(hclk), .hresetn(hresetn), .take(take), .close(close),
        .post_err(post_err), .up_trans(s_htrans), .up_burst(s_hburst),
        .open(open), .fwd_trans(fwd_trans), .fwd_burst(fwd_burst)
    );

    // Register the accepted address phase for the downstream side
    always_ff @(posedge hclk) begin
        if (!hresetn) begin
            addr_q  <= '0;
            trans_q <= TR_IDLE;
            write_q <= 1'b0;
            size_q  <= '0;
            burst_q <= BR_SINGLE;
        end else if (take) begin
            addr_q  <= s_haddr;
            trans_q <= fwd_trans;
            write_q <= s_hwrite;
            size_q  <= s_hsize;
            burst_q <= fwd_burst;
        end
    end

    // Downstream transfer type: beat, burst gap, or forced idle
    always_comb begin
        case (state)
            ST_ADDR: m_htrans = trans_q;
            ST_DATA: m_htrans = (!m_hresp && open) ? TR_BUSY : TR_IDLE;
            ST_IDLE: m_htrans = open ? TR_BUSY : TR_IDLE;
            default: m_htrans = TR_IDLE;
        endcase
    end

    // Address, control and data connections
    always_comb begin
        m_haddr  = addr_q;
        m_hwrite = write_q;
        m_hsize  = size_q;
        m_hburst = burst_q;
        m_hwdata = s_hwdata;
        s_hrdata = m_hrdata;
    end

endmodule

// File: rtl/ahb_burst_bridge_chk.sv
// Module: protocol checker for ahb_burst_bridge, bound to every instance.
module ahb_burst_bridge_chk (
    input logic       hclk,
    input logic       hresetn,
    input logic [1:0] m_htrans,
    input logic       m_hready,
    input logic       m_hresp,
    input logic       s_hreadyout,
    input logic       s_hresp
);
    // A downstream beat stalls the master in the same cycle
    p_beat_stall_r2: assert property (@(posedge hclk) disable iff (!hresetn)
        m_htrans[1] |-> !s_hreadyout);

    // SEQ downstream always follows a BUSY gap, so bursts stay legal
    p_seq_after_gap_r3: assert property (@(posedge hclk) disable iff (!hresetn)
        (m_htrans == 2'b11) |-> ($past(m_htrans) == 2'b01));

    // First downstream error cycle leads to the stalled upstream error cycle
    p_err_first_r5: assert property (@(posedge hclk) disable iff (!hresetn)
        (m_hresp && !m_hready) |=> (s_hresp && !s_hreadyout));

    // Stalled upstream error cycle is followed by the completing one
    p_err_second_r5: assert property (@(posedge hclk) disable iff (!hresetn)
        (s_hresp && !s_hreadyout) |=> (s_hresp && s_hreadyout));

    // No downstream activity while the error is being relayed
    p_err_idle_r6: assert property (@(posedge hclk) disable iff (!hresetn)
        s_hresp |-> (m_htrans == 2'b00));

endmodule

bind ahb_burst_bridge ahb_burst_bridge_chk u_chk (
    .hclk(hclk), .hresetn(hresetn), .m_htrans(m_htrans),
    .m_hready(m_hready), .m_hresp(m_hresp),
    .s_hreadyout(s_hreadyout), .s_hresp(s_hresp)
);

// File: tb/ahb_burst_bridge_tb.sv
module ahb_burst_bridge_tb;
    localparam int TMO = 5;
    localparam logic [1:0] I = 2'b00, B = 2'b01, N = 2'b10, S = 2'b11;

    logic        hclk = 1'b0;
    logic        hresetn = 1'b0;
    logic [31:0] s_haddr = '0, s_hwdata = '0, m_hrdata = '0;
    logic [1:0]  s_htrans = I;
    logic        s_hwrite = 1'b1;
    logic [2:0]  s_hsize = 3'd2, s_hburst = 3'd0;
    logic [31:0] s_hrdata, m_haddr, m_hwdata;
    logic        s_hreadyout, s_hresp, m_hwrite, m_hready = 1'b1, m_hresp = 1'b0;
    logic [1:0]  m_htrans;
    logic [2:0]  m_hsize, m_hburst;
    int          n_run = 0, n_fail = 0, cyc_cnt = 0;

    always #10 hclk = ~hclk;

    ahb_burst_bridge #(.AW(32), .DW(32), .TMO(TMO)) u_dut (
        .hclk(hclk), .hresetn(hresetn), .s_haddr(s_haddr), .s_htrans(s_htrans),
        .s_hwrite(s_hwrite), .s_hsize(s_hsize), .s_hburst(s_hburst),
        .s_hwdata(s_hwdata), .s_hrdata(s_hrdata), .s_hreadyout(s_hreadyout),
        .s_hresp(s_hresp), .m_haddr(m_haddr), .m_htrans(m_htrans),
        .m_hwrite(m_hwrite), .m_hsize(m_hsize), .m_hburst(m_hburst),
        .m_hwdata(m_hwdata), .m_hrdata(m_hrdata), .m_hready(m_hready),
        .m_hresp(m_hresp)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check combinational outputs mid-low phase
    task automatic cyc(input logic [1:0] t, input logic [31:0] a, input logic [2:0] b,
                       input logic r, input logic e, input logic [1:0] et,
                       input logic erdy, input logic eresp, input string tag);
        @(negedge hclk);
        s_htrans = t; s_haddr = a; s_hburst = b; m_hready = r; m_hresp = e;
        s_hwdata = a ^ 32'hA5A5_0000; m_hrdata = ~a;
        #5;
        chk({tag, " m_htrans"}, 32'(m_htrans), 32'(et));
        chk({tag, " s_hreadyout"}, 32'(s_hreadyout), 32'(erdy));
        chk({tag, " s_hresp"}, 32'(s_hresp), 32'(eresp));
        chk("R2 wdata pass", m_hwdata, a ^ 32'hA5A5_0000);
        chk("R2 rdata pass", s_hrdata, ~a);
    endtask

    task automatic chk_addr(input string tag, input logic [31:0] a, input logic [2:0] b);
        chk({tag, " m_haddr"}, m_haddr, a);
        chk({tag, " m_hburst"}, 32'(m_hburst), 32'(b));
        chk({tag, " m_hwrite"}, 32'(m_hwrite), 32'd1);
        chk({tag, " m_hsize"}, 32'(m_hsize), 32'd2);
    endtask

    // INCR4 at 0x100 whose second beat receives the two-cycle downstream error
    task automatic err_prefix();
        cyc(N, 32'h100, 3, 1, 0, I, 1, 0, "R2 pre");
        cyc(S, 32'h104, 3, 1, 0, N, 0, 0, "R2 pre");
        cyc(S, 32'h104, 3, 1, 0, B, 1, 0, "R3 pre");
        cyc(S, 32'h108, 3, 1, 0, S, 0, 0, "R3 pre");
        cyc(S, 32'h108, 3, 0, 1, I, 0, 0, "R6 first err");
        cyc(S, 32'h108, 3, 1, 1, I, 0, 1, "R5 err cycle 1");
    endtask

    always @(posedge hclk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected < 20000", cyc_cnt);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge hclk);
        #5;
        chk("R1 reset m_htrans", 32'(m_htrans), 32'd0);
        chk("R1 reset s_hreadyout", 32'(s_hreadyout), 32'd1);
        chk("R1 reset s_hresp", 32'(s_hresp), 32'd0);
        @(negedge hclk);
        hresetn = 1'b1;
        #5;
        chk("R1 after reset m_htrans", 32'(m_htrans), 32'd0);

        // R3: every burst code, error-free
        for (int b = 0; b < 8; b++) begin
            int n;
            n = (b == 0) ? 1 : (b == 1) ? 3 : (1 << ((b / 2) + 1));
            for (int k = 0; k < n; k++) begin
                logic [31:0] a;
                a = 32'h1000 * (b + 1) + 4 * k;
                cyc(k == 0 ? N : S, a, 3'(b), 1, 0, k == 0 ? I : B, 1, 0, "R3 gap before beat");
                cyc(k == 0 ? N : S, a, 3'(b), 1, 0, k == 0 ? N : S, 0, 0, "R2 beat");
                chk_addr("R2 beat", a, 3'(b));
            end
            cyc(I, 0, 0, 1, 0, b == 1 ? B : I, 1, 0, "R3 gap after last");
            cyc(I, 0, 0, 1, 0, I, 1, 0, "R3 idle");
        end

        // R4: upstream BUSY inside a burst
        cyc(N, 32'h400, 3, 1, 0, I, 1, 0, "R4 start");
        cyc(B, 32'h404, 3, 1, 0, N, 0, 0, "R4 beat0");
        cyc(B, 32'h404, 3, 1, 0, B, 1, 0, "R4 busy accepted");
        cyc(S, 32'h404, 3, 1, 0, B, 1, 0, "R4 busy forwarded");
        cyc(S, 32'h408, 3, 1, 0, S, 0, 0, "R4 seq after busy");
        chk_addr("R4 seq", 32'h404, 3);
        cyc(I, 0, 0, 1, 0, B, 1, 0, "R4 open gap");
        cyc(I, 0, 0, 1, 0, I, 1, 0, "R4 close");

        // R7: immediate continuation with SEQ
        err_prefix();
        cyc(S, 32'h108, 3, 1, 0, I, 1, 1, "R5 err cycle 2");
        cyc(S, 32'h10C, 3, 1, 0, N, 0, 0, "R7 resume as NONSEQ");
        chk_addr("R7 resume", 32'h108, 1);
        cyc(S, 32'h10C, 3, 1, 0, B, 1, 0, "R7 busy gap");
        cyc(S, 32'h10C, 3, 1, 0, S, 0, 0, "R7 next SEQ");
        chk_addr("R7 next", 32'h10C, 1);
        cyc(I, 0, 0, 1, 0, B, 1, 0, "R7 INCR tail");
        cyc(I, 0, 0, 1, 0, I, 1, 0, "R7 idle");

        // R8: cancellation by IDLE
        err_prefix();
        cyc(I, 0, 0, 1, 0, I, 1, 1, "R8 err cycle 2");
        cyc(I, 0, 0, 1, 0, I, 1, 0, "R8 cancelled");
        cyc(N, 32'h200, 0, 1, 0, I, 1, 0, "R8 new single");
        cyc(I, 0, 0, 1, 0, N, 0, 0, "R8 single beat");
        chk_addr("R8 single", 32'h200, 0);
        cyc(I, 0, 0, 1, 0, I, 1, 0, "R8 single gap");

        // R9: BUSY wait then continuation
        err_prefix();
        cyc(B, 32'h108, 3, 1, 0, I, 1, 1, "R9 err cycle 2 busy");
        cyc(B, 32'h108, 3, 1, 0, I, 1, 0, "R9 waiting");
        cyc(S, 32'h108, 3, 1, 0, I, 1, 0, "R9 decide");
        cyc(S, 32'h10C, 3, 1, 0, N, 0, 0, "R9 resume");
        chk_addr("R9 resume", 32'h108, 1);
        cyc(I, 0, 0, 1, 0, B, 1, 0, "R9 INCR gap");
        cyc(I, 0, 0, 1, 0, I, 1, 0, "R9 idle");

        // R11: new NONSEQ after error
        err_prefix();
        cyc(N, 32'h300, 0, 1, 0, I, 1, 1, "R11 err cycle 2");
        cyc(I, 0, 0, 1, 0, N, 0, 0, "R11 forwarded");
        chk_addr("R11 forwarded", 32'h300, 0);
        cyc(I, 0, 0, 1, 0, I, 1, 0, "R11 gap");

        // R10: full timeout, late SEQ stands alone
        err_prefix();
        cyc(B, 32'h108, 3, 1, 0, I, 1, 1, "R10 err cycle 2");
        for (int w = 0; w < TMO; w++) cyc(B, 32'h108, 3, 1, 0, I, 1, 0, "R10 waiting");
        cyc(B, 32'h108, 3, 1, 0, I, 1, 0, "R10 after expiry");
        cyc(S, 32'h108, 3, 1, 0, I, 1, 0, "R10 late SEQ");
        cyc(S, 32'h10C, 3, 1, 0, N, 0, 0, "R10 late beat");
        chk_addr("R10 late beat single", 32'h108, 0);
        cyc(I, 0, 0, 1, 0, I, 1, 0, "R10 single gap");

        // R10 boundary: SEQ in the last waiting cycle still continues
        err_prefix();
        cyc(B, 32'h108, 3, 1, 0, I, 1, 1, "R10b err cycle 2");
        for (int w = 0; w < TMO - 1; w++) cyc(B, 32'h108, 3, 1, 0, I, 1, 0, "R10b waiting");
        cyc(S, 32'h108, 3, 1, 0, I, 1, 0, "R10b last-cycle SEQ");
        cyc(S, 32'h10C, 3, 1, 0, N, 0, 0, "R10b resume");
        chk_addr("R10b resume INCR", 32'h108, 1);
        cyc(I, 0, 0, 1, 0, B, 1, 0, "R10b INCR gap");
        cyc(I, 0, 0, 1, 0, I, 1, 0, "R10b idle");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule